// File: doc/BRIEF.md
# Serial Flash Page-Program Sequencer

This block is the host-side engine that commits one page of data to a serial flash. The flash has two on-chip SRAM buffers. Software hands it a page number, a choice of buffer and a page-size mode, then pulses `start`. The block then streams exactly one page of bytes from a valid/ready source into the chosen buffer. Next it tells the flash to erase and program that page from the buffer. Finally it reads the flash status byte until the ready bit appears or a programmable poll budget runs out.

The serial link is SPI mode 0. The clock idles low, output data changes while the clock is low, and input data is sampled on the rising edge. Bytes go out most significant bit first. The SCK half-period is the parameter `HALF`, counted in system clocks. The three transfers are issued as three separate chip-select frames: the buffer load, the program commit and the status poll. Between frames, and after the last one, chip select stays high for `4*HALF` clocks, which is two SCK periods. The flash starts its self-timed program only when chip select rises after the commit frame.

The controller has nine states. `ST_IDLE` waits for `start`. `ST_BUF_HDR` sends the buffer-load opcode and three address bytes. `ST_BUF_DATA` moves the page bytes. `ST_GAP_A` is a chip-select-high gap. `ST_PRG_HDR` sends the commit opcode and address. `ST_GAP_B` is the gap that launches programming. `ST_STAT_OP` sends the status opcode. `ST_STAT_RD` clocks in status bytes. `ST_TAIL` is the closing gap.

The transitions are:
- start: `ST_IDLE` → `ST_BUF_HDR`.
- hdr-sent: `ST_BUF_HDR` → `ST_BUF_DATA`.
- page-filled: `ST_BUF_DATA` → `ST_GAP_A`.
- gap-out: `ST_GAP_A` → `ST_PRG_HDR`.
- hdr-sent: `ST_PRG_HDR` → `ST_GAP_B`.
- gap-out: `ST_GAP_B` → `ST_STAT_OP`.
- op-sent: `ST_STAT_OP` → `ST_STAT_RD`.
- ready-seen or budget-spent: `ST_STAT_RD` → `ST_TAIL`.
- not-ready: `ST_STAT_RD` → `ST_STAT_RD`.
- gap-out: `ST_TAIL` → `ST_IDLE`, with the done pulse.

Top module: `flash_page_writer`

## Requirements
- R1: During and after reset, until `start`, `cs_n` is 1, `sck` is 0, `in_ready` is 0 and `done` is 0.
- R2: The first frame is the opcode, three address bytes, then exactly one page of stream bytes in arrival order. The opcode is 8'h84 when `buf_two`=0 and 8'h87 when `buf_two`=1. A page is 528 bytes when `short_page`=0 and 512 bytes when `short_page`=1.
- R3: The 24-bit address is sent high byte first, and the column part is zero. With `short_page`=0, the page number sits in bits 22:10. With `short_page`=1, it sits in bits 21:9. All higher bits are zero.
- R4: The second frame has exactly four bytes: 8'h83 (`buf_two`=0) or 8'h86 (`buf_two`=1), then the same three address bytes.
- R5: The third frame starts with 8'hD7. It then reads status bytes with chip select held low. It closes after the first status byte whose bit 7 is 1.
- R6: At most `poll_limit` status bytes are read, and a limit of 0 acts as 1. If none of them has bit 7 set, `err` is 1 at `done`.
- R7: `done` is a one-cycle pulse after the poll frame and its closing gap. `err` is 0 on success. `err` holds its value until the next accepted `start`, which clears it.
- R8: Whenever `cs_n` is 1, `sck` is 0. Every rise of `cs_n` is followed by at least `4*HALF` clocks of high before it falls again.
- R9: SPI mode 0: `mosi` does not change while `sck` is 1.
- R10: `in_ready` is 1 only inside the data phase, with `cs_n` low. A byte moves only on `in_valid` and `in_ready` both 1. Gaps in `in_valid` lose no byte and add none.
- R11: A `start` pulse while an operation is in progress has no effect. No extra frame appears and the data is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin one page program (used in idle only) |
| page_idx | input | PAGE_W | Page number to program |
| buf_two | input | 1 | 0 selects buffer 1, 1 selects buffer 2 |
| short_page | input | 1 | 1 selects the 512-byte page mode |
| poll_limit | input | LIMIT_W | Largest number of status bytes to read |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Block takes a stream byte |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Poll budget spent without ready |
| cs_n | output | 1 | Flash chip select, active low |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |

## Verification
The assertions assume that the flash drives `miso` only from the falling edge of `sck`, so the value is settled at the next rising edge. They also assume that `page_idx`, `buf_two`, `short_page` and `poll_limit` are valid on the cycle `start` is taken, and that the stream never supplies more bytes than one page. The bench meets these assumptions with a behavioural flash model. The model shifts status bits out on falling `sck` and returns a scripted number of not-ready bytes before a ready one. The stream is driven only on falling clock edges, which also produces the valid gaps. A stray `start` is injected only during the data phase, where the design must ignore it.

// File: rtl/fpw_pkg.sv
package fpw_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_BUF_HDR,
        ST_BUF_DATA,
        ST_GAP_A,
        ST_PRG_HDR,
        ST_GAP_B,
        ST_STAT_OP,
        ST_STAT_RD,
        ST_TAIL
    } seq_state_t;

    localparam logic [7:0] OP_LOAD_B1 = 8'h84;
    localparam logic [7:0] OP_LOAD_B2 = 8'h87;
    localparam logic [7:0] OP_PROG_B1 = 8'h83;
    localparam logic [7:0] OP_PROG_B2 = 8'h86;
    localparam logic [7:0] OP_STATUS  = 8'hD7;
    localparam logic [7:0] FILL_BYTE  = 8'h00;

    // byte idx of a 32-bit header word, highest byte first
    function automatic logic [7:0] hdr_byte(input logic [31:0] word, input logic [1:0] idx);
        return word[8*(3-int'(idx)) +: 8];
    endfunction

endpackage

// File: rtl/fpw_addr_pack.sv
module fpw_addr_pack #(
    parameter int PAGE_W = 13,
    parameter int COL_W  = 10
) (
    input  logic [PAGE_W-1:0] page,
    input  logic              short_mode,
    output logic [23:0]       addr
);
    logic [23:0] long_addr;
    logic [23:0] short_addr;

    always_comb begin
        long_addr  = 24'(page) << COL_W;
        short_addr = 24'(page) << (COL_W - 1);
        addr       = short_mode ? short_addr : long_addr;
    end
endmodule

// File: rtl/fpw_sck_engine.sv
module fpw_sck_engine #(
    parameter int HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       busy,
    output logic       done,
    output logic       rx_first
);
    localparam int DW = (HALF > 1) ? $clog2(HALF) : 1;

    logic          busy_q, sck_q, done_q, first_q;
    logic [DW-1:0] div_q;
    logic [2:0]    bit_q;
    logic [7:0]    sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            sck_q   <= 1'b0;
            done_q  <= 1'b0;
            first_q <= 1'b0;
            div_q   <= '0;
            bit_q   <= '0;
            sr_q    <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (go) begin
                    busy_q <= 1'b1;
                    sr_q   <= tx;
                    div_q  <= '0;
                    bit_q  <= '0;
                    sck_q  <= 1'b0;
                end
            end else if (div_q == DW'(HALF - 1)) begin
                div_q <= '0;
                if (!sck_q) begin
                    sck_q <= 1'b1;
                    if (bit_q == 3'd0) first_q <= miso;
                end else begin
                    sck_q <= 1'b0;
                    if (bit_q == 3'd7) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 3'd1;
                        sr_q  <= {sr_q[6:0], 1'b0};
                    end
                end
            end else begin
                div_q <= div_q + DW'(1);
            end
        end
    end

    assign sck      = sck_q;
    assign mosi     = sr_q[7];
    assign busy     = busy_q;
    assign done     = done_q;
    assign rx_first = first_q;

    AST_MOSI_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        sck_q |-> $stable(mosi));  // R9
endmodule

// File: rtl/flash_page_writer.sv
module flash_page_writer
    import fpw_pkg::*;
#(
    parameter int PAGE_W      = 13,
    parameter int LONG_BYTES  = 528,
    parameter int SHORT_BYTES = 512,
    parameter int HALF        = 2,
    parameter int LIMIT_W     = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [PAGE_W-1:0]  page_idx,
    input  logic               buf_two,
    input  logic               short_page,
    input  logic [LIMIT_W-1:0] poll_limit,
    input  logic               in_valid,
    input  logic [7:0]         in_data,
    output logic               in_ready,
    output logic               done,
    output logic               err,
    output logic               cs_n,
    output logic               sck,
    output logic               mosi,
    input  logic               miso
);
    localparam int COL_W   = $clog2(LONG_BYTES);
    localparam int CNT_W   = $clog2(LONG_BYTES + 1);
    localparam int GAP_CLK = 4 * HALF;
    localparam int GAP_W   = $clog2(GAP_CLK + 1);

    seq_state_t         state_q, state_d;
    logic [PAGE_W-1:0]  page_q;
    logic               buf_q, short_q, infl_q, err_q, done_q;
    logic [LIMIT_W-1:0] limit_q, poll_q;
    logic [1:0]         idx_q;
    logic [CNT_W-1:0]   data_q, last_data;
    logic [GAP_W-1:0]   gap_q;
    logic [23:0]        addr;
    logic               gap_end, poll_stop, in_gap;
    logic               eng_go, eng_busy, eng_done, eng_first;
    logic [7:0]         eng_tx;

    fpw_addr_pack #(.PAGE_W(PAGE_W), .COL_W(COL_W)) u_addr (
        .page(page_q), .short_mode(short_q), .addr(addr)
    );

    fpw_sck_engine #(.HALF(HALF)) u_eng (
        .clk(clk), .rst_n(rst_n), .go(eng_go), .tx(eng_tx), .miso(miso),
        .sck(sck), .mosi(mosi), .busy(eng_busy), .done(eng_done), .rx_first(eng_first)
    );

    always_comb begin
        last_data = short_q ? CNT_W'(SHORT_BYTES - 1) : CNT_W'(LONG_BYTES - 1);
        gap_end   = (gap_q == GAP_W'(GAP_CLK - 1));
        poll_stop = eng_first ||
                    (({1'b0, poll_q} + (LIMIT_W+1)'(1)) >= {1'b0, limit_q});
        in_gap    = (state_q == ST_GAP_A) || (state_q == ST_GAP_B) || (state_q == ST_TAIL);
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = ST_BUF_HDR;
            ST_BUF_HDR:  if (eng_done && idx_q == 2'd3) state_d = ST_BUF_DATA;
            ST_BUF_DATA: if (eng_done && data_q == last_data) state_d = ST_GAP_A;
            ST_GAP_A:    if (gap_end) state_d = ST_PRG_HDR;
            ST_PRG_HDR:  if (eng_done && idx_q == 2'd3) state_d = ST_GAP_B;
            ST_GAP_B:    if (gap_end) state_d = ST_STAT_OP;
            ST_STAT_OP:  if (eng_done) state_d = ST_STAT_RD;
            ST_STAT_RD:  if (eng_done && poll_stop) state_d = ST_TAIL;
            ST_TAIL:     if (gap_end) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            page_q  <= '0;
            buf_q   <= 1'b0;
            short_q <= 1'b0;
            limit_q <= '0;
            poll_q  <= '0;
            idx_q   <= '0;
            data_q  <= '0;
            gap_q   <= '0;
            infl_q  <= 1'b0;
            err_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_TAIL) && gap_end;
            if (eng_go) infl_q <= 1'b1;
            else if (eng_done) infl_q <= 1'b0;
            if (state_q == ST_IDLE && start) begin
                page_q  <= page_idx;
                buf_q   <= buf_two;
                short_q <= short_page;
                limit_q <= poll_limit;
                poll_q  <= '0;
                err_q   <= 1'b0;
            end
            if (state_d != state_q) begin
                idx_q  <= '0;
                data_q <= '0;
                gap_q  <= '0;
            end else begin
                if (eng_done) begin
                    idx_q  <= idx_q + 2'd1;
                    data_q <= data_q + CNT_W'(1);
                end
                if (in_gap) gap_q <= gap_q + GAP_W'(1);
            end
            if (state_q == ST_STAT_RD && eng_done) begin
                poll_q <= poll_q + LIMIT_W'(1);
                if (poll_stop && !eng_first) err_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        cs_n     = 1'b0;
        eng_go   = 1'b0;
        eng_tx   = FILL_BYTE;
        in_ready = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_GAP_A, ST_GAP_B, ST_TAIL: cs_n = 1'b1;
            ST_BUF_HDR: begin
                eng_go = !infl_q;
                eng_tx = hdr_byte({buf_q ? OP_LOAD_B2 : OP_LOAD_B1, addr}, idx_q);
            end
            ST_BUF_DATA: begin
                in_ready = !infl_q;
                eng_go   = !infl_q && in_valid;
                eng_tx   = in_data;
            end
            ST_PRG_HDR: begin
                eng_go = !infl_q;
                eng_tx = hdr_byte({buf_q ? OP_PROG_B2 : OP_PROG_B1, addr}, idx_q);
            end
            ST_STAT_OP: begin
                eng_go = !infl_q;
                eng_tx = OP_STATUS;
            end
            ST_STAT_RD: eng_go = !infl_q;
            default:    cs_n = 1'b1;
        endcase
    end

    assign done = done_q;
    assign err  = err_q;

    // high-time counter for chip select, saturating
    logic [GAP_W-1:0] hi_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hi_cnt <= GAP_W'(GAP_CLK);
        else if (!cs_n) hi_cnt <= '0;
        else if (hi_cnt != GAP_W'(GAP_CLK)) hi_cnt <= hi_cnt + GAP_W'(1);
    end

    AST_CS_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);  // R8
    AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (hi_cnt >= GAP_W'(GAP_CLK)));  // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R7
    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STAT_RD) |-> (poll_q < limit_q || poll_q == '0));  // R6
    AST_READY_ENGINE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !eng_busy);  // R10
endmodule

// File: tb/test_flash_page_writer.sv
module test_flash_page_writer;
    localparam int BH  = 1;
    localparam int GAP = 4 * BH;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [12:0] page_idx = '0;
    logic        buf_two = 1'b0;
    logic        short_page = 1'b0;
    logic [15:0] poll_limit = '0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready, done, err, cs_n, sck, mosi;
    logic        miso = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    flash_page_writer #(.HALF(BH)) i_flash_page_writer (
        .clk(clk), .rst_n(rst_n), .start(start), .page_idx(page_idx),
        .buf_two(buf_two), .short_page(short_page), .poll_limit(poll_limit),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .done(done), .err(err), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural flash: frame logger and status responder
    logic [7:0] fb[$];
    int         fs[$];
    int         fl[$];
    int         bitc = 0;
    int         busy_left = 0;
    logic [7:0] shin = '0, outsr = '0, frame_op = '0;

    always @(negedge cs_n) begin
        fs.push_back(fb.size());
        bitc = 0;
    end
    always @(posedge cs_n) begin
        if (fs.size() > fl.size()) fl.push_back(fb.size() - fs[fs.size()-1]);
    end
    always @(posedge sck) begin
        if (!cs_n) begin
            shin = {shin[6:0], mosi};
            bitc++;
            if (bitc % 8 == 0) begin
                fb.push_back(shin);
                if (bitc == 8) frame_op = shin;
            end
        end
    end
    always @(negedge sck) begin
        if (!cs_n && bitc >= 8 && frame_op == 8'hD7) begin
            if (bitc % 8 == 0) begin
                if (busy_left > 0) begin
                    outsr = 8'h2C;
                    busy_left--;
                end else begin
                    outsr = 8'hAC;
                end
            end else begin
                outsr = {outsr[6:0], 1'b0};
            end
            miso = outsr[7];
        end
    end

    // per-clock protocol reference
    int   hi_run = 1000;
    logic prev_cs = 1'b1, prev_sck = 1'b0, prev_mosi = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            chk(!(cs_n && sck), "R8 sck low while deselected", sck, 0);
            if (!cs_n && prev_cs)
                chk(hi_run >= GAP, "R8 deselect gap", hi_run, GAP);
            if (sck && prev_sck)
                chk(mosi == prev_mosi, "R9 mosi held while sck high", mosi, prev_mosi);
            if (in_ready)
                chk(!cs_n, "R10 in_ready only inside data frame", cs_n, 0);
            hi_run = cs_n ? hi_run + 1 : 0;
            prev_cs = cs_n;
            prev_sck = sck;
            prev_mosi = mosi;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic run_page(input bit b2, input int pg, input bit sh, input int busy,
                            input int lim, input bit stall, input bit poke,
                            input int exp_polls, input bit exp_err);
        int n;
        int a;
        int k;
        int i;
        int bad;
        logic [7:0] d[$];
        n = sh ? 512 : 528;
        a = sh ? (pg << 9) : (pg << 10);
        fb.delete(); fs.delete(); fl.delete();
        busy_left = busy;
        for (int j = 0; j < n; j++) d.push_back(8'((j * 13 + pg) & 255));
        @(negedge clk);
        page_idx = 13'(pg); buf_two = b2; short_page = sh; poll_limit = 16'(lim);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(err == 1'b0, "R7 err cleared by start", err, 0);
        i = 0; k = 0;
        while (i < n) begin
            @(negedge clk);
            k++;
            start = (poke && i == 100) ? 1'b1 : 1'b0;   // R11 stray start
            if (stall && (k % 3 == 0)) in_valid = 1'b0;
            else begin
                in_valid = 1'b1;
                in_data = d[i];
            end
            if (in_valid && in_ready) i++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        start = 1'b0;
        while (!done) @(negedge clk);
        chk(err == exp_err, "R6 err at done", err, exp_err);
        @(negedge clk);
        chk(done == 1'b0, "R7 done lasts one cycle", done, 0);
        repeat (10) @(negedge clk);
        chk(err == exp_err, "R7 err held after done", err, exp_err);
        chk(fl.size() == 3, "R11 exactly three frames", fl.size(), 3);
        if (fl.size() == 3) begin
            chk(fl[0] == n + 4, "R2 load frame length", fl[0], n + 4);
            chk(fb[fs[0]] == (b2 ? 8'h87 : 8'h84), "R2 load opcode", fb[fs[0]], b2 ? 8'h87 : 8'h84);
            chk({fb[fs[0]+1], fb[fs[0]+2], fb[fs[0]+3]} == 24'(a), "R3 load address",
                {fb[fs[0]+1], fb[fs[0]+2], fb[fs[0]+3]}, a);
            bad = 0;
            for (int j = 0; j < n && j + 4 < fl[0]; j++)
                if (fb[fs[0]+4+j] != d[j]) bad++;
            chk(bad == 0, "R10 data bytes in order", bad, 0);
            chk(fl[1] == 4, "R4 commit frame length", fl[1], 4);
            chk(fb[fs[1]] == (b2 ? 8'h86 : 8'h83), "R4 commit opcode", fb[fs[1]], b2 ? 8'h86 : 8'h83);
            chk({fb[fs[1]+1], fb[fs[1]+2], fb[fs[1]+3]} == 24'(a), "R4 commit address",
                {fb[fs[1]+1], fb[fs[1]+2], fb[fs[1]+3]}, a);
            chk(fb[fs[2]] == 8'hD7, "R5 poll opcode", fb[fs[2]], 8'hD7);
            chk(fl[2] == 1 + exp_polls, "R5 status bytes read", fl[2] - 1, exp_polls);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1 && sck == 1'b0, "R1 reset lines", {cs_n, sck}, 2'b10);
        chk(in_ready == 1'b0 && done == 1'b0, "R1 reset handshake", {in_ready, done}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1 && sck == 1'b0 && in_ready == 1'b0, "R1 idle after reset",
            {cs_n, sck, in_ready}, 3'b100);
        run_page(1'b0, 5,       1'b0, 3,   10, 1'b0, 1'b0, 4, 1'b0); // R2 R3 R5
        run_page(1'b1, 13'h1FFF, 1'b0, 0,  10, 1'b1, 1'b1, 1, 1'b0); // R10 R11
        run_page(1'b0, 13'h1555, 1'b1, 1,   4, 1'b0, 1'b0, 2, 1'b0); // R3 short mode
        run_page(1'b1, 3,       1'b1, 100,  5, 1'b0, 1'b0, 5, 1'b1); // R6 timeout
        run_page(1'b0, 7,       1'b1, 100,  0, 1'b0, 1'b0, 1, 1'b1); // R6 zero limit
        run_page(1'b1, 13'h0AAA, 1'b1, 2,   3, 1'b1, 1'b0, 3, 1'b0); // R6 limit edge
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule